// File: doc/BRIEF.md
# Radix-2 FFT Stage Address Sequencer

This block drives the memories of an iterative, in-place-free radix-2 FFT of N points. The data lives in two sets of split real/imaginary memories that trade places every stage: one set is read as butterfly operands while the other collects butterfly results. The arithmetic unit and the memories sit outside; this block only decides, cycle by cycle, which addresses are read, which twiddle factor is fetched, whether the two operand banks are crossed over, and where the two results of each butterfly land.

After a start request the block runs all log2(N) stages without any further handshake. Each stage is split into two halves of N/4 butterflies. Operands are fetched on consecutive addresses, and the twiddle address steps by a stage-dependent stride that wraps within N/2 entries. Results lag their operands by one cycle, so each half ends with a write-only drain cycle. The two halves place their results on opposite even/odd address lanes. A quiet cycle separates consecutive stages so that a stage never reads a bank the previous stage is still writing. A one-cycle done pulse ends the run and the block waits for the next start.

Top module: `fft_stage_seq`

## Requirements
- R1: While idle, with start low, rd_en, wr_en and done stay low; a high start seen at a clock edge launches a run whose first read is visible right after that edge.
- R2: Stages are numbered 1 to log2(N) on stage_num, one after another; src_bank is 0 during odd-numbered stages and 1 during even-numbered ones.
- R3: Each stage has two halves of N/4 read cycles each; the operand read address is 0 at the first read of a stage and rises by 1 on every read, continuing across the half boundary up to N/2-1.
- R4: rd_swap, which crosses operand banks a and b, is 1 exactly on reads whose read address is odd (the odd cycles of the stage).
- R5: On the read with stage-relative index j in stage s, tw_addr equals (j * (N >> s)) modulo N/2.
- R6: The k-th result of a half (k = 0 .. N/4-1) is written to wr_addr_a = 2k + La and wr_addr_b = 2k + Lb, where (La, Lb) = (0, 1) in the first half and (1, 0) in the second half.
- R7: wr_en is low in the first cycle of every half, is high in the cycle after each read, and the cycle after the last read of a half is a write-only drain cycle.
- R8: Between two stages there is exactly one cycle with rd_en, wr_en and done all low.
- R9: After the drain cycle of the final stage, done is high for exactly one cycle with no read or write, and the block is then idle and can be started again.
- R10: start is ignored while a run is in progress; the run's address sequence is unchanged.
- R11: While rst_n is low, rd_en, wr_en and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when seen high while idle |
| rd_en | output | 1 | Operand and twiddle read strobe |
| rd_addr | output | log2(N)-1 | Operand read address, common to both operand banks |
| rd_swap | output | 1 | 1: operand bank b feeds the a input and vice versa |
| tw_addr | output | log2(N)-1 | Twiddle memory read address |
| wr_en | output | 1 | Result write strobe for both result banks |
| wr_addr_a | output | log2(N)-1 | Write address in the a-result bank |
| wr_addr_b | output | log2(N)-1 | Write address in the b-result bank |
| src_bank | output | 1 | Which memory set is the operand source this stage |
| stage_num | output | clog2(log2(N)+1) | Current stage number, 1-based |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Every output is a register loaded from the next-state decode, so the first read of a run is on the ports in the cycle right after the edge that sees start, and every later cycle of the schedule follows at one cycle per clock. A result is due on the write port exactly one cycle after its operand read, and the inter-stage quiet cycle and the done pulse each take one cycle. The bench walks a computed schedule (per stage, half and cycle) in lock step with the clock, sampling on the falling edge after each rising edge, so each expected value is compared in the cycle it is due, including a start pulse injected mid-run and a second back-to-back run.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_GAP  = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_e;

endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
  import fft_seq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  output logic [$clog2($clog2(N)+1)-1:0] stage_q,
  output logic                          rd_en_q,
  output logic                          wr_en_q,
  output logic                          done_q,
  output logic                          nxt_stage_first,
  output logic                          nxt_half_first,
  output logic                          nxt_half,
  output logic                          nxt_wr
);

  localparam int NSTG = $clog2(N);
  localparam int HB   = N / 4;
  localparam int CW   = $clog2(HB + 1);
  localparam int SW   = $clog2(NSTG + 1);

  seq_state_e       st_q, st_d;
  logic [SW-1:0]    stage_d;
  logic             half_q, half_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             nxt_rd;
  logic             seq_adv;

  // next-state decode
  always_comb begin
    st_d    = st_q;
    stage_d = stage_q;
    half_d  = half_q;
    cnt_d   = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d    = SQ_RUN;
          stage_d = SW'(1);
          half_d  = 1'b0;
          cnt_d   = '0;
        end
      end
      SQ_RUN: begin
        if (cnt_q == CW'(HB)) begin
          cnt_d = '0;
          if (!half_q) begin
            half_d = 1'b1;
          end else if (stage_q == SW'(NSTG)) begin
            st_d = SQ_DONE;
          end else begin
            st_d = SQ_GAP;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      SQ_GAP: begin
        st_d    = SQ_RUN;
        stage_d = stage_q + SW'(1);
        half_d  = 1'b0;
        cnt_d   = '0;
      end
      SQ_DONE: begin
        st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  assign nxt_rd          = (st_d == SQ_RUN) && (cnt_d != CW'(HB));
  assign nxt_wr          = (st_d == SQ_RUN) && (cnt_d != '0);
  assign nxt_half_first  = (st_d == SQ_RUN) && (cnt_d == '0);
  assign nxt_stage_first = nxt_half_first && !half_d;
  assign nxt_half        = half_d;

  // clock enable: the sequencer only moves while running or on a start request
  assign seq_adv = (st_q != SQ_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      stage_q <= '0;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (seq_adv) begin
      st_q    <= st_d;
      stage_q <= stage_d;
      half_q  <= half_d;
      cnt_q   <= cnt_d;
      rd_en_q <= nxt_rd;
      wr_en_q <= nxt_wr;
      done_q  <= (st_d == SQ_DONE);
    end
  end

  // R2
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_q |-> (stage_q >= SW'(1)) && (stage_q <= SW'(NSTG)));

  // R7
  write_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> ($past(rd_en_q) || $past(wr_en_q)));

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_en_q) |-> wr_en_q);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !rd_en_q && !wr_en_q);

endmodule

// File: rtl/fft_seq_rdgen.sv
module fft_seq_rdgen #(
  parameter int N = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           stage_first,
  input  logic                           rd_en_q,
  input  logic [$clog2($clog2(N)+1)-1:0] stage_q,
  output logic [$clog2(N)-2:0]           rd_addr_q,
  output logic [$clog2(N)-2:0]           tw_addr_q
);

  localparam int AW = $clog2(N);
  localparam int HW = AW - 1;

  logic [HW-1:0] rd_addr_d, tw_addr_d;
  logic [AW-1:0] stride;
  logic [AW-1:0] tw_sum;
  logic          gen_adv;

  assign stride  = AW'(N >> stage_q);
  assign tw_sum  = {1'b0, tw_addr_q} + stride;
  assign gen_adv = stage_first || rd_en_q;

  always_comb begin
    rd_addr_d = rd_addr_q;
    tw_addr_d = tw_addr_q;
    if (stage_first) begin
      rd_addr_d = '0;
      tw_addr_d = '0;
    end else if (rd_en_q) begin
      rd_addr_d = rd_addr_q + HW'(1);
      tw_addr_d = tw_sum[HW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      tw_addr_q <= '0;
    end else if (gen_adv) begin
      rd_addr_q <= rd_addr_d;
      tw_addr_q <= tw_addr_d;
    end
  end

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_q && $past(rd_en_q) |-> rd_addr_q == $past(rd_addr_q) + HW'(1));

  // R5
  tw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_first) |-> tw_addr_q == '0);

endmodule

// File: rtl/fft_seq_wrgen.sv
module fft_seq_wrgen #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_first,
  input  logic                 half_sel,
  input  logic                 wr_next,
  input  logic                 wr_en_q,
  output logic [$clog2(N)-2:0] wr_a_q,
  output logic [$clog2(N)-2:0] wr_b_q
);

  localparam int HW = $clog2(N) - 1;

  logic [HW-1:0] wr_a_d, wr_b_d;
  logic [HW-1:0] lane_a, lane_b;
  logic          wr_adv;

  // lane offsets trade places in the second half of a stage
  assign lane_a = half_sel ? HW'(1) : HW'(0);
  assign lane_b = half_sel ? HW'(0) : HW'(1);
  assign wr_adv = half_first || wr_next;

  always_comb begin
    wr_a_d = wr_a_q;
    wr_b_d = wr_b_q;
    if (half_first) begin
      wr_a_d = lane_a - HW'(2);
      wr_b_d = lane_b - HW'(2);
    end else if (wr_next) begin
      wr_a_d = wr_a_q + HW'(2);
      wr_b_d = wr_b_q + HW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_a_q <= '0;
      wr_b_q <= '0;
    end else if (wr_adv) begin
      wr_a_q <= wr_a_d;
      wr_b_q <= wr_b_d;
    end
  end

  // R6
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q && $past(wr_en_q) |-> wr_a_q == $past(wr_a_q) + HW'(2));

  // R6
  wr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> wr_a_q[0] != wr_b_q[0]);

endmodule

// File: rtl/fft_stage_seq.sv
module fft_stage_seq #(
  parameter int N = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           rd_en,
  output logic [$clog2(N)-2:0]           rd_addr,
  output logic                           rd_swap,
  output logic [$clog2(N)-2:0]           tw_addr,
  output logic                           wr_en,
  output logic [$clog2(N)-2:0]           wr_addr_a,
  output logic [$clog2(N)-2:0]           wr_addr_b,
  output logic                           src_bank,
  output logic [$clog2($clog2(N)+1)-1:0] stage_num,
  output logic                           done
);

  localparam int AW = $clog2(N);
  localparam int SW = $clog2(AW + 1);

  logic          stage_first, half_first, half_sel, wr_next;
  logic [SW-1:0] stage_q;
  logic          rd_en_q, wr_en_q, done_q;

  fft_seq_ctrl #(.N(N)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .stage_q         (stage_q),
    .rd_en_q         (rd_en_q),
    .wr_en_q         (wr_en_q),
    .done_q          (done_q),
    .nxt_stage_first (stage_first),
    .nxt_half_first  (half_first),
    .nxt_half        (half_sel),
    .nxt_wr          (wr_next)
  );

  fft_seq_rdgen #(.N(N)) u_rdgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_first (stage_first),
    .rd_en_q     (rd_en_q),
    .stage_q     (stage_q),
    .rd_addr_q   (rd_addr),
    .tw_addr_q   (tw_addr)
  );

  fft_seq_wrgen #(.N(N)) u_wrgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_first (half_first),
    .half_sel   (half_sel),
    .wr_next    (wr_next),
    .wr_en_q    (wr_en_q),
    .wr_a_q     (wr_addr_a),
    .wr_b_q     (wr_addr_b)
  );

  assign rd_en     = rd_en_q;
  assign wr_en     = wr_en_q;
  assign done      = done_q;
  assign stage_num = stage_q;
  assign src_bank  = ~stage_q[0];
  assign rd_swap   = rd_addr[0];

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !rd_en && !wr_en && !done);

  // R8
  stage_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !$past(rd_en) && !$past(wr_en) && $past(stage_num) != 0
      |-> $past(done) || $past(stage_num) != stage_num);

endmodule

// File: tb/tb_fft_stage_seq.sv
module tb_fft_stage_seq;

  localparam int N    = 16;
  localparam int AW   = $clog2(N);
  localparam int HW   = AW - 1;
  localparam int NSTG = AW;
  localparam int HB   = N / 4;
  localparam int SW   = $clog2(NSTG + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          rd_en, rd_swap, wr_en, src_bank, done;
  logic [HW-1:0] rd_addr, tw_addr, wr_addr_a, wr_addr_b;
  logic [SW-1:0] stage_num;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fft_stage_seq #(.N(N)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_swap   (rd_swap),
    .tw_addr   (tw_addr),
    .wr_en     (wr_en),
    .wr_addr_a (wr_addr_a),
    .wr_addr_b (wr_addr_b),
    .src_bank  (src_bank),
    .stage_num (stage_num),
    .done      (done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // walks one complete run; start already sampled, now in the first cycle
  task automatic follow_run(input bit inject);
    for (int s = 1; s <= NSTG; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c <= HB; c++) begin
          int j = h * HB + c;
          check("R2 stage_num", int'(stage_num), s);
          check("R2 src_bank", int'(src_bank), (s % 2 == 0) ? 1 : 0);
          check("R3 rd_en", int'(rd_en), (c < HB) ? 1 : 0);
          if (c < HB) begin
            check("R3 rd_addr", int'(rd_addr), j);
            check("R4 rd_swap", int'(rd_swap), j % 2);
            check("R5 tw_addr", int'(tw_addr), (j * (N >> s)) % (N / 2));
          end
          check("R7 wr_en", int'(wr_en), (c > 0) ? 1 : 0);
          if (c > 0) begin
            check("R6 wr_addr_a", int'(wr_addr_a), 2 * (c - 1) + h);
            check("R6 wr_addr_b", int'(wr_addr_b), 2 * (c - 1) + (1 - h));
          end
          check("R9 done low in run", int'(done), 0);
          // R10: a start pulse in the middle of the run
          start = inject && (s == 2) && (h == 0) && (c == 1);
          @(negedge clk);
        end
      end
      if (s < NSTG) begin
        check("R8 gap rd_en", int'(rd_en), 0);
        check("R8 gap wr_en", int'(wr_en), 0);
        check("R8 gap done", int'(done), 0);
        @(negedge clk);
      end
    end
    start = 1'b0;
    check("R9 done pulse", int'(done), 1);
    check("R9 done rd_en", int'(rd_en), 0);
    check("R9 done wr_en", int'(wr_en), 0);
    @(negedge clk);
    check("R9 done falls", int'(done), 0);
    check("R9 idle rd_en", int'(rd_en), 0);
    check("R9 idle wr_en", int'(wr_en), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset rd_en", int'(rd_en), 0);
    check("R11 reset wr_en", int'(wr_en), 0);
    check("R11 reset done", int'(done), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 idle rd_en", int'(rd_en), 0);
      check("R1 idle wr_en", int'(wr_en), 0);
      check("R1 idle done", int'(done), 0);
    end
    // first run, with a stray start pulse mid-run (R10)
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 first read after start", int'(rd_en), 1);
    follow_run(1'b1);
    // stays idle after the run
    repeat (4) @(negedge clk);
    check("R9 stays idle", int'(rd_en), 0);
    // second run back from idle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 restart read", int'(rd_en), 1);
    follow_run(1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule